// File: doc/BRIEF.md
# Serial Configuration Write Port

This block receives 16-bit configuration words over a three-wire serial link (data, shift clock, commit strobe) and stores each one into one of three registers: a left gain word, a right gain word and a mode register. All three wires are treated as asynchronous to the core clock. They are brought in through a synchronizer and oversampled, so the core clock must be fast enough that the shift clock and the strobe each stay high and low for at least three core cycles. The shift clock may toggle freely between words. Only a rising strobe commits a word.

Each word carries a two-bit register select in its two least significant bits and a 14-bit payload above them. A small controller FSM with three states decides what a rising strobe does. In ST_COLLECT the serial bits are shifting in. On a strobe rise with an acceptable word the FSM goes to ST_APPLY. On a strobe rise with a refused word it goes to ST_REJECT. Both ST_APPLY and ST_REJECT return to ST_COLLECT unconditionally after one cycle.

The mode register fields drive configuration outputs. Where a board-level strap exists, the strap is merged with the register bit. Each gain write also produces a one-cycle update pulse that a downstream gain ramp can use.

Top module: `scp_port`

## Requirements
- R1: After reset, with all straps low: both gain outputs are 14'h3FFF, every configuration output is zero (2x and 4x off, 24-bit length code 00, no soft reset, unmuted, format 00, de-emphasis 00), and no update pulse is high.
- R2: Serial bits shift in MSB first, one bit per rising edge of `ser_clk`. The committed word is the last 16 bits shifted before the strobe rises, so any earlier bits are dropped.
- R3: Select 00 in word bits 1:0 writes word bits 15:2 to `vol_left`.
- R4: Select 10 writes word bits 15:2 to `vol_right`. A single word never updates both gains.
- R5: Select 01 with word bits 15:12 all zero writes the mode register, with these fields:
  - bit 11: 2x
  - bit 10: 4x
  - bits 9:8: word length (00=24, 01=20, 10=16)
  - bit 7: soft reset
  - bit 6: mute
  - bits 5:4: format (00 right-justified, 01 I2S, 10 left-justified, 11 DSP)
  - bits 3:2: de-emphasis (00 off, 01 44.1 kHz, 10 32 kHz, 11 48 kHz)
- R6: A word with select 11, or a select-01 word with any of bits 15:12 set, changes no output and produces no pulse.
- R7: A committed word takes effect on the third rising core edge after the first core edge that samples `ser_lat` high. A gain write raises its update pulse for exactly that one cycle, even when the value is unchanged. Mode writes raise no pulse.
- R8: Straps are ORed into the register bits for 2x, 4x, mute and format. `pin_deemp` high forces de-emphasis code 01.
- R9: Activity on `ser_clk` and `ser_dat` without a rising strobe leaves every output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Commit strobe, rising edge active |
| pin_x2 | input | 1 | Strap for 2x rate |
| pin_x4 | input | 1 | Strap for 4x rate |
| pin_mute | input | 1 | Strap for mute |
| pin_fmt | input | 2 | Strap for serial format |
| pin_deemp | input | 1 | Strap forcing 44.1 kHz de-emphasis |
| vol_left | output | 14 | Left gain word |
| vol_right | output | 14 | Right gain word |
| vol_left_upd | output | 1 | One-cycle pulse on left gain write |
| vol_right_upd | output | 1 | One-cycle pulse on right gain write |
| cfg_x2 | output | 1 | Effective 2x select |
| cfg_x4 | output | 1 | Effective 4x select |
| cfg_wlen | output | 2 | Word length code |
| cfg_srst | output | 1 | Soft reset bit |
| cfg_mute | output | 1 | Effective mute |
| cfg_fmt | output | 2 | Effective serial format |
| cfg_deemp | output | 2 | Effective de-emphasis code |

## Verification
The word patterns are chosen so that each one separates a different behaviour:
- Distinct gain payloads, including all zeros and all ones, show which register each select reaches and whether any payload bit is lost or swapped.
- Two mode words with complementary field values expose any misplaced field boundary.
- A 20-bit burst with junk leading bits shows that only the trailing 16 bits count.
- Refused words (select 11, reserved bits set) and free-running shift clocks without a strobe must leave every output unchanged.
- Straps are then raised against register values that differ from them, which tells an OR merge apart from a replace.

// File: rtl/scp_pkg.sv
package scp_pkg;

    typedef enum logic [1:0] {
        SEL_VOL_L = 2'b00,
        SEL_CTRL  = 2'b01,
        SEL_VOL_R = 2'b10,
        SEL_NONE  = 2'b11
    } sel_e;

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_APPLY   = 2'd1,
        ST_REJECT  = 2'd2
    } fsm_e;

    // Mode fields, packed LSB-aligned to payload bit 0 (word bit 2).
    typedef struct packed {
        logic       x2;
        logic       x4;
        logic [1:0] wlen;
        logic       srst;
        logic       mute;
        logic [1:0] fmt;
        logic [1:0] deemp;
    } ctrl_t;

    localparam int          RSV_W      = 4;
    localparam logic [1:0]  DEEMP_44K1 = 2'b01;

endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[0] <= '0;
                else        pipe[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe[i] <= '0;
                else        pipe[i] <= pipe[i-1];
            end
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/scp_shift.sv
module scp_shift #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_lvl,
    input  logic              sdat_lvl,
    output logic [WORD_W-1:0] word
);
    logic sclk_prev;
    logic sclk_rise;

    assign sclk_rise = sclk_lvl & ~sclk_prev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev <= 1'b0;
            word      <= '0;
        end else begin
            sclk_prev <= sclk_lvl;
            if (sclk_rise) word <= {word[WORD_W-2:0], sdat_lvl};
        end
    end
endmodule

// File: rtl/scp_fsm.sv
module scp_fsm
    import scp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lat_lvl,
    input  logic [WORD_W-1:0] word_in,
    output logic              wr_en,
    output logic [WORD_W-1:0] wr_word
);
    fsm_e              state_q, state_d;
    logic              lat_prev;
    logic              lat_rise;
    logic [WORD_W-1:0] hold_q;
    logic              refused;
    sel_e              sel_in;

    assign lat_rise = lat_lvl & ~lat_prev;
    assign sel_in   = sel_e'(word_in[SEL_W-1:0]);
    assign refused  = (sel_in == SEL_NONE) ||
                      ((sel_in == SEL_CTRL) && (word_in[WORD_W-1 -: RSV_W] != '0));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COLLECT: if (lat_rise) state_d = refused ? ST_REJECT : ST_APPLY;
            ST_APPLY:   state_d = ST_COLLECT;
            ST_REJECT:  state_d = ST_COLLECT;
            default:    state_d = ST_COLLECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_COLLECT;
            lat_prev <= 1'b0;
        end else begin
            state_q  <= state_d;
            lat_prev <= lat_lvl;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                     hold_q <= '0;
        else if (state_q == ST_COLLECT && lat_rise)     hold_q <= word_in;
    end

    always_comb begin
        wr_en   = (state_q == ST_APPLY);
        wr_word = hold_q;
    end
endmodule

// File: rtl/scp_regs.sv
module scp_regs
    import scp_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 2,
    localparam int PAY_W = WORD_W - SEL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_word,
    output logic [PAY_W-1:0]  vol_l,
    output logic [PAY_W-1:0]  vol_r,
    output ctrl_t             ctrl,
    output logic              upd_l,
    output logic              upd_r
);
    logic [PAY_W-1:0] pay;
    sel_e             sel;

    assign pay = wr_word[WORD_W-1:SEL_W];
    assign sel = sel_e'(wr_word[SEL_W-1:0]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vol_l <= '1;
            vol_r <= '1;
            ctrl  <= '0;
            upd_l <= 1'b0;
            upd_r <= 1'b0;
        end else begin
            upd_l <= 1'b0;
            upd_r <= 1'b0;
            if (wr_en) begin
                unique case (sel)
                    SEL_VOL_L: begin vol_l <= pay; upd_l <= 1'b1; end
                    SEL_VOL_R: begin vol_r <= pay; upd_r <= 1'b1; end
                    SEL_CTRL:  ctrl <= pay[$bits(ctrl_t)-1:0];
                    default:   ;
                endcase
            end
        end
    end
endmodule

// File: rtl/scp_port.sv
module scp_port
    import scp_pkg::*;
#(
    parameter int WORD_W      = 16,
    parameter int SEL_W       = 2,
    parameter int SYNC_STAGES = 2,
    localparam int PAY_W      = WORD_W - SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_clk,
    input  logic             ser_dat,
    input  logic             ser_lat,
    input  logic             pin_x2,
    input  logic             pin_x4,
    input  logic             pin_mute,
    input  logic [1:0]       pin_fmt,
    input  logic             pin_deemp,
    output logic [PAY_W-1:0] vol_left,
    output logic [PAY_W-1:0] vol_right,
    output logic             vol_left_upd,
    output logic             vol_right_upd,
    output logic             cfg_x2,
    output logic             cfg_x4,
    output logic [1:0]       cfg_wlen,
    output logic             cfg_srst,
    output logic             cfg_mute,
    output logic [1:0]       cfg_fmt,
    output logic [1:0]       cfg_deemp
);
    logic [2:0]        sync_q;
    logic [WORD_W-1:0] shift_word;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;
    ctrl_t             ctrl;

    scp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ser_lat, ser_dat, ser_clk}),
        .q     (sync_q)
    );

    scp_shift #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_lvl (sync_q[0]),
        .sdat_lvl (sync_q[1]),
        .word     (shift_word)
    );

    scp_fsm #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .lat_lvl (sync_q[2]),
        .word_in (shift_word),
        .wr_en   (wr_en),
        .wr_word (wr_word)
    );

    scp_regs #(.WORD_W(WORD_W), .SEL_W(SEL_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_word (wr_word),
        .vol_l   (vol_left),
        .vol_r   (vol_right),
        .ctrl    (ctrl),
        .upd_l   (vol_left_upd),
        .upd_r   (vol_right_upd)
    );

    // Strap merge
    assign cfg_x2    = ctrl.x2   | pin_x2;
    assign cfg_x4    = ctrl.x4   | pin_x4;
    assign cfg_mute  = ctrl.mute | pin_mute;
    assign cfg_fmt   = ctrl.fmt  | pin_fmt;
    assign cfg_wlen  = ctrl.wlen;
    assign cfg_srst  = ctrl.srst;
    assign cfg_deemp = pin_deemp ? DEEMP_44K1 : ctrl.deemp;
endmodule

// File: rtl/scp_port_chk.sv
module scp_port_chk #(
    parameter int PAY_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [PAY_W-1:0] vol_left,
    input logic [PAY_W-1:0] vol_right,
    input logic             vol_left_upd,
    input logic             vol_right_upd,
    input logic [1:0]       cfg_wlen
);
    assert_lpulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vol_left_upd |=> !vol_left_upd);

    assert_rpulse_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        vol_right_upd |=> !vol_right_upd);

    assert_pulse_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(vol_left_upd && vol_right_upd));

    assert_pulse_after_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vol_left_upd || vol_right_upd) |-> $past(wr_en));

    assert_lvol_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vol_left_upd |-> $stable(vol_left));

    assert_rvol_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !vol_right_upd |-> $stable(vol_right));

    assert_wlen_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(cfg_wlen));
endmodule

bind scp_port scp_port_chk #(.PAY_W(PAY_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .vol_left      (vol_left),
    .vol_right     (vol_right),
    .vol_left_upd  (vol_left_upd),
    .vol_right_upd (vol_right_upd),
    .cfg_wlen      (cfg_wlen)
);

// File: tb/sim_scp_port.sv
module sim_scp_port;
    localparam int CLK_P    = 10;
    localparam int LATENCY  = 4;
    localparam int WATCHDOG = 60000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
    logic pin_x2 = 1'b0, pin_x4 = 1'b0, pin_mute = 1'b0, pin_deemp = 1'b0;
    logic [1:0] pin_fmt = 2'b00;
    logic [13:0] vol_left, vol_right;
    logic vol_left_upd, vol_right_upd;
    logic cfg_x2, cfg_x4, cfg_srst, cfg_mute;
    logic [1:0] cfg_wlen, cfg_fmt, cfg_deemp;

    int unsigned cyc = 0;
    int total = 0;
    int bad = 0;
    string phase = "R1";

    // reference model state
    logic [13:0] m_vl = 14'h3FFF, m_vr = 14'h3FFF;
    logic [15:0] m_ctl = 16'h0000;
    logic m_pl = 1'b0, m_pr = 1'b0;
    logic [15:0] w;
    int unsigned due_q[$];
    logic [15:0] word_q[$];

    scp_port u0 (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
        .pin_x2(pin_x2), .pin_x4(pin_x4), .pin_mute(pin_mute), .pin_fmt(pin_fmt),
        .pin_deemp(pin_deemp), .vol_left(vol_left), .vol_right(vol_right),
        .vol_left_upd(vol_left_upd), .vol_right_upd(vol_right_upd),
        .cfg_x2(cfg_x2), .cfg_x4(cfg_x4), .cfg_wlen(cfg_wlen), .cfg_srst(cfg_srst),
        .cfg_mute(cfg_mute), .cfg_fmt(cfg_fmt), .cfg_deemp(cfg_deemp)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s (phase %s) %s actual=%h expected=%h at cycle %0d",
                     req, phase, what, act, exp, cyc);
        end
    endtask

    task automatic end_run;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // cycle-by-cycle model and comparison, sampled away from the edge
    always @(posedge clk) begin
        cyc++;
        #2;
        if (cyc > WATCHDOG) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected<%0d", cyc, WATCHDOG);
            end_run();
        end
        if (!rst_n) begin
            m_vl = 14'h3FFF; m_vr = 14'h3FFF; m_ctl = 16'h0; m_pl = 0; m_pr = 0;
            due_q.delete(); word_q.delete();
        end else begin
            m_pl = 0; m_pr = 0;
            while (due_q.size() > 0 && due_q[0] == cyc) begin
                void'(due_q.pop_front());
                w = word_q.pop_front();
                case (w[1:0])
                    2'b00: begin m_vl = w[15:2]; m_pl = 1; end
                    2'b10: begin m_vr = w[15:2]; m_pr = 1; end
                    2'b01: if (w[15:12] == 4'h0) m_ctl = w;
                    default: ;
                endcase
            end
        end
        chk("R3", "vol_left", 32'(vol_left), 32'(m_vl));
        chk("R4", "vol_right", 32'(vol_right), 32'(m_vr));
        chk("R7", "upd pulses", {30'd0, vol_left_upd, vol_right_upd}, {30'd0, m_pl, m_pr});
        chk("R5/R8", "cfg_x2", 32'(cfg_x2), 32'(m_ctl[11] | pin_x2));
        chk("R5/R8", "cfg_x4", 32'(cfg_x4), 32'(m_ctl[10] | pin_x4));
        chk("R5", "cfg_wlen", 32'(cfg_wlen), 32'(m_ctl[9:8]));
        chk("R5", "cfg_srst", 32'(cfg_srst), 32'(m_ctl[7]));
        chk("R5/R8", "cfg_mute", 32'(cfg_mute), 32'(m_ctl[6] | pin_mute));
        chk("R5/R8", "cfg_fmt", 32'(cfg_fmt), 32'(m_ctl[5:4] | pin_fmt));
        chk("R5/R8", "cfg_deemp", 32'(cfg_deemp), 32'(pin_deemp ? 2'b01 : m_ctl[3:2]));
    end

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic shift_bits(input logic [31:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = bits[i];
            ser_clk = 1'b0;
            gap(3);
            ser_clk = 1'b1;
            gap(3);
        end
        ser_clk = 1'b0;
        gap(3);
    endtask

    task automatic send(input logic [31:0] bits, input int n);
        shift_bits(bits, n);
        ser_lat = 1'b1;
        due_q.push_back(cyc + LATENCY);
        word_q.push_back(bits[15:0]);
        gap(3);
        ser_lat = 1'b0;
        gap(8);
    endtask

    initial begin
        gap(4);
        // R1: reset state
        chk("R1", "vol_left reset", 32'(vol_left), 32'h3FFF);
        chk("R1", "vol_right reset", 32'(vol_right), 32'h3FFF);
        chk("R1", "cfg reset", {cfg_x2, cfg_x4, cfg_wlen, cfg_srst, cfg_mute, cfg_fmt, cfg_deemp}, 32'h0);
        rst_n = 1'b1;
        gap(5);

        phase = "R3";
        send(32'h48D0, 16);                 // payload 14'h1234, select 00
        chk("R3", "left write", 32'(vol_left), 32'h1234);
        phase = "R4";
        send(32'h2AF2, 16);                 // payload 14'h0ABC, select 10
        chk("R4", "right write", 32'(vol_right), 32'h0ABC);
        chk("R4", "left untouched", 32'(vol_left), 32'h1234);
        send(32'hFFFE, 16);                 // right all ones
        send(32'h0000, 16);                 // left all zeros
        chk("R3", "left zero", 32'(vol_left), 32'h0);

        phase = "R5";
        send(32'h0AAD, 16);
        chk("R5", "mode A", {cfg_x2, cfg_x4, cfg_wlen, cfg_srst, cfg_mute, cfg_fmt, cfg_deemp},
            32'b1_0_10_1_0_10_11);
        send(32'h0559, 16);
        chk("R5", "mode B", {cfg_x2, cfg_x4, cfg_wlen, cfg_srst, cfg_mute, cfg_fmt, cfg_deemp},
            32'b0_1_01_0_1_01_10);

        phase = "R6";
        send(32'h1AAD, 16);                 // reserved bit set
        send(32'hFFFF, 16);                 // select 11
        chk("R6", "mode kept", {cfg_x2, cfg_x4, cfg_wlen, cfg_srst, cfg_mute, cfg_fmt, cfg_deemp},
            32'b0_1_01_0_1_01_10);
        chk("R6", "right kept", 32'(vol_right), 32'h3FFF);

        phase = "R2";
        send(32'hA0004, 20);                // junk 1010, then payload 1 to left
        chk("R2", "trailing 16 bits", 32'(vol_left), 32'h0001);

        phase = "R7";
        send(32'h0004, 16);                 // same value again still pulses

        phase = "R9";
        shift_bits(32'h0000C3A5, 16);       // shifting, no strobe
        shift_bits(32'h00005A5A, 16);
        chk("R9", "left after free shift", 32'(vol_left), 32'h0001);
        chk("R9", "mode after free shift", 32'(cfg_wlen), 32'h1);

        phase = "R8";
        pin_x2 = 1'b1; gap(3);
        chk("R8", "x2 strap", 32'(cfg_x2), 32'h1);
        pin_fmt = 2'b10; gap(3);
        chk("R8", "fmt merge", 32'(cfg_fmt), 32'h3);
        pin_deemp = 1'b1; gap(3);
        chk("R8", "deemp forced", 32'(cfg_deemp), 32'h1);
        send(32'h0001, 16);                 // clear mode register
        pin_mute = 1'b1; pin_x4 = 1'b1; gap(3);
        chk("R8", "mute strap", 32'(cfg_mute), 32'h1);
        chk("R8", "x4 strap", 32'(cfg_x4), 32'h1);
        pin_x2 = 0; pin_x4 = 0; pin_mute = 0; pin_fmt = 0; pin_deemp = 0;
        gap(3);
        chk("R8", "straps released", {cfg_x2, cfg_x4, cfg_mute, cfg_fmt, cfg_deemp}, 32'h0);

        phase = "R7";
        send(32'hFFFC, 16);                 // left all ones
        send(32'h0006, 16);                 // right payload 1
        gap(10);
        end_run();
    end
endmodule